// File: doc/BRIEF.md
# Register Window Spill/Fill Accounting Unit

This block keeps the bookkeeping state of a windowed register file: how many windows may still be saved into, how many may be restored from, how many belong to another context, how many are known clean, the current window pointer, and a small window-state register that selects trap vectors. It does not hold any register contents. It only decides, per command, whether the window move is legal.

Five command strobes drive it: save, restore, flush-windows, saved and restored. When a command is legal, the counters and the window pointer move together in one clock edge. When it is not legal, all state is kept as it was, and a one-cycle trap request goes out with a computed trap-type code. Software-visible state is loaded through per-register write enables that share a data bus. Any write in a cycle takes precedence over all commands in that cycle.

Trap codes come from parameterised base values. For spill and fill traps, a three-bit field of the window-state register is merged into bits 4:2 of the code. Which field is used depends on whether any other-context windows exist.

Top module: `win_acct_unit`

## Requirements
- R1: After reset, the save count is NWIN-2, the window pointer is 0, the restore count and other count are 0, the clean count is NWIN-1, the window-state register is 0 and the trap output is low.
- R2: A save with save count 0 raises a spill trap whose code is SPILL_BASE merged with the window-state selection of R6.
- R3: A save with a nonzero save count, where the clean count equals the restore count, raises a trap with code CLEAN_CODE.
- R4: Any other save decrements the save count, increments the restore count and lowers the window pointer by one, going from 0 to NWIN-1.
- R5: A restore with restore count 0 raises a fill trap (FILL_BASE merged per R6). Otherwise it increments the save count, decrements the restore count and raises the window pointer by one, going from NWIN-1 to 0.
- R6: The spill or fill code is the base ORed with a selection value. When the other count is nonzero, the selection is OTHER_FLAG ORed with window-state bits 5:3 placed at code bits 4:2. When the other count is zero, the selection is window-state bits 2:0 placed at code bits 4:2.
- R7: A flush-windows command raises a spill trap (code per R2) unless the save count equals NWIN-2. It never changes any counter or the window pointer.
- R8: A saved command increments the save count. It also decrements the other count if that count is nonzero, or decrements the restore count if it is zero.
- R9: A restored command increments the restore count. It increments the clean count only while that count is below NWIN-1. It also decrements the other count if that count is nonzero, or decrements the save count if it is zero.
- R10: A command that traps leaves every counter and the window pointer unchanged.
- R11: The trap output is registered. It is high for exactly the cycle after the trapping command's edge, and low after any cycle with no trapping command.
- R12: At most one command acts per cycle, with priority save, restore, flush, saved, restored. Any register write enable in a cycle ignores all commands in that cycle, and the write takes effect at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdSave | input | 1 | Save command strobe |
| cmdRestore | input | 1 | Restore command strobe |
| cmdFlush | input | 1 | Flush-windows command strobe |
| cmdSaved | input | 1 | Saved command strobe |
| cmdRestored | input | 1 | Restored command strobe |
| wrCansave | input | 1 | Write save count from wrCntData |
| wrCanrestore | input | 1 | Write restore count from wrCntData |
| wrOtherwin | input | 1 | Write other count from wrCntData |
| wrCleanwin | input | 1 | Write clean count from wrCntData |
| wrCwp | input | 1 | Write window pointer from wrCntData |
| wrCntData | input | CNT_W | Shared counter write data |
| wrWstate | input | 1 | Write window-state register |
| wrWstateData | input | 6 | Window-state write data |
| cansave | output | CNT_W | Save count |
| canrestore | output | CNT_W | Restore count |
| otherwin | output | CNT_W | Other-context count |
| cleanwin | output | CNT_W | Clean count |
| cwp | output | CNT_W | Current window pointer |
| wstate | output | 6 | Window-state register |
| trapValid | output | 1 | Trap request, one cycle |
| trapType | output | TT_W | Trap-type code |

## Verification
On every cycle, the assertions check several rules. A trapping command leaves the counters frozen. A save at zero save count always traps. A legal flush and a cycle with no command stay quiet. A restored command at the clean ceiling keeps the clean count there. The window-pointer wrap at both ends is also checked as it happens. The exact trap codes depend on which window-state field is chosen, so only the bench scenarios show them. The same holds for the saved/restored choice between the other count and the normal counters, command priority, and write precedence over commands. Those scenarios compare the results against values computed from the requirements.

// File: rtl/win_acct_pkg.sv
package win_acct_pkg;
  typedef struct packed {
    logic csInc;
    logic csDec;
    logic crInc;
    logic crDec;
    logic owDec;
    logic clInc;
    logic cwpDn;
    logic cwpUp;
  } win_stb_t;
endpackage

// File: rtl/win_acct_ctrl.sv
module win_acct_ctrl
  import win_acct_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int CNT_W = 3,
  parameter int TT_W = 9,
  parameter logic [TT_W-1:0] SPILL_BASE = 9'h080,
  parameter logic [TT_W-1:0] FILL_BASE = 9'h0C0,
  parameter logic [TT_W-1:0] CLEAN_CODE = 9'h024,
  parameter logic [TT_W-1:0] OTHER_FLAG = 9'h020
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdSave,
  input  logic             cmdRestore,
  input  logic             cmdFlush,
  input  logic             cmdSaved,
  input  logic             cmdRestored,
  input  logic             anyWr,
  input  logic [CNT_W-1:0] cansave,
  input  logic [CNT_W-1:0] canrestore,
  input  logic [CNT_W-1:0] otherwin,
  input  logic [CNT_W-1:0] cleanwin,
  input  logic [5:0]       wstate,
  output win_stb_t         stb,
  output logic             trapValid,
  output logic [TT_W-1:0]  trapType
);
  localparam logic [CNT_W-1:0] FLUSH_OK = CNT_W'(NWIN - 2);
  localparam logic [CNT_W-1:0] CLEAN_MAX = CNT_W'(NWIN - 1);

  logic [TT_W-1:0]  selCode;
  logic [CNT_W-1:0] cleanGap;
  logic             trapNext;
  logic [TT_W-1:0]  codeNext;
  logic             owBusy;

  assign owBusy   = (otherwin != '0);
  assign cleanGap = cleanwin - canrestore;
  assign selCode  = owBusy ? (OTHER_FLAG | (TT_W'(wstate[5:3]) << 2))
                           : (TT_W'(wstate[2:0]) << 2);

  always_comb begin
    stb      = '0;
    trapNext = 1'b0;
    codeNext = '0;
    if (!anyWr) begin
      if (cmdSave) begin
        if (cansave == '0) begin
          trapNext = 1'b1;
          codeNext = SPILL_BASE | selCode;
        end else if (cleanGap == '0) begin
          trapNext = 1'b1;
          codeNext = CLEAN_CODE;
        end else begin
          stb.csDec = 1'b1;
          stb.crInc = 1'b1;
          stb.cwpDn = 1'b1;
        end
      end else if (cmdRestore) begin
        if (canrestore == '0) begin
          trapNext = 1'b1;
          codeNext = FILL_BASE | selCode;
        end else begin
          stb.csInc = 1'b1;
          stb.crDec = 1'b1;
          stb.cwpUp = 1'b1;
        end
      end else if (cmdFlush) begin
        if (cansave != FLUSH_OK) begin
          trapNext = 1'b1;
          codeNext = SPILL_BASE | selCode;
        end
      end else if (cmdSaved) begin
        stb.csInc = 1'b1;
        stb.owDec = owBusy;
        stb.crDec = !owBusy;
      end else if (cmdRestored) begin
        stb.crInc = 1'b1;
        stb.clInc = (cleanwin < CLEAN_MAX);
        stb.owDec = owBusy;
        stb.csDec = !owBusy;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trapValid <= 1'b0;
      trapType  <= '0;
    end else begin
      trapValid <= trapNext;
      trapType  <= trapNext ? codeNext : '0;
    end
  end

  AST_SPILL_ON_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (cmdSave && !anyWr && cansave == '0) |=> trapValid); // R2

  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (cmdFlush && !cmdSave && !cmdRestore && !anyWr && cansave == FLUSH_OK) |=> !trapValid); // R7

  AST_IDLE_NO_TRAP: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdSave && !cmdRestore && !cmdFlush) |=> !trapValid); // R11
endmodule

// File: rtl/win_acct_dp.sv
module win_acct_dp
  import win_acct_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  win_stb_t         stb,
  input  logic             wrCansave,
  input  logic             wrCanrestore,
  input  logic             wrOtherwin,
  input  logic             wrCleanwin,
  input  logic             wrCwp,
  input  logic [CNT_W-1:0] wrCntData,
  input  logic             wrWstate,
  input  logic [5:0]       wrWstateData,
  output logic [CNT_W-1:0] cansave,
  output logic [CNT_W-1:0] canrestore,
  output logic [CNT_W-1:0] otherwin,
  output logic [CNT_W-1:0] cleanwin,
  output logic [CNT_W-1:0] cwp,
  output logic [5:0]       wstate
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NWIN - 1);
  localparam logic [CNT_W-1:0] CS_RST = CNT_W'(NWIN - 2);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cansave    <= CS_RST;
      canrestore <= '0;
      otherwin   <= '0;
      cleanwin   <= LAST;
      cwp        <= '0;
      wstate     <= '0;
    end else begin
      if (wrCansave)       cansave <= wrCntData;
      else if (stb.csInc)  cansave <= cansave + 1'b1;
      else if (stb.csDec)  cansave <= cansave - 1'b1;

      if (wrCanrestore)    canrestore <= wrCntData;
      else if (stb.crInc)  canrestore <= canrestore + 1'b1;
      else if (stb.crDec)  canrestore <= canrestore - 1'b1;

      if (wrOtherwin)      otherwin <= wrCntData;
      else if (stb.owDec)  otherwin <= otherwin - 1'b1;

      if (wrCleanwin)      cleanwin <= wrCntData;
      else if (stb.clInc)  cleanwin <= cleanwin + 1'b1;

      if (wrCwp)           cwp <= wrCntData;
      else if (stb.cwpDn)  cwp <= (cwp == '0) ? LAST : cwp - 1'b1;
      else if (stb.cwpUp)  cwp <= (cwp == LAST) ? '0 : cwp + 1'b1;

      if (wrWstate)        wstate <= wrWstateData;
    end
  end

  AST_CWP_WRAP_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (stb.cwpDn && !wrCwp && cwp == '0) |=> (cwp == LAST)); // R4

  AST_CWP_WRAP_UP: assert property (@(posedge clk) disable iff (!rstN)
    (stb.cwpUp && !wrCwp && cwp == LAST) |=> (cwp == '0)); // R5
endmodule

// File: rtl/win_acct_unit.sv
module win_acct_unit
  import win_acct_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int TT_W = 9,
  parameter logic [TT_W-1:0] SPILL_BASE = 9'h080,
  parameter logic [TT_W-1:0] FILL_BASE = 9'h0C0,
  parameter logic [TT_W-1:0] CLEAN_CODE = 9'h024,
  parameter logic [TT_W-1:0] OTHER_FLAG = 9'h020,
  localparam int CNT_W = $clog2(NWIN)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdSave,
  input  logic             cmdRestore,
  input  logic             cmdFlush,
  input  logic             cmdSaved,
  input  logic             cmdRestored,
  input  logic             wrCansave,
  input  logic             wrCanrestore,
  input  logic             wrOtherwin,
  input  logic             wrCleanwin,
  input  logic             wrCwp,
  input  logic [CNT_W-1:0] wrCntData,
  input  logic             wrWstate,
  input  logic [5:0]       wrWstateData,
  output logic [CNT_W-1:0] cansave,
  output logic [CNT_W-1:0] canrestore,
  output logic [CNT_W-1:0] otherwin,
  output logic [CNT_W-1:0] cleanwin,
  output logic [CNT_W-1:0] cwp,
  output logic [5:0]       wstate,
  output logic             trapValid,
  output logic [TT_W-1:0]  trapType
);
  localparam logic [CNT_W-1:0] CLEAN_MAX = CNT_W'(NWIN - 1);

  win_stb_t stb;
  logic     anyWr;

  assign anyWr = wrCansave | wrCanrestore | wrOtherwin | wrCleanwin | wrCwp | wrWstate;

  win_acct_ctrl #(
    .NWIN(NWIN), .CNT_W(CNT_W), .TT_W(TT_W),
    .SPILL_BASE(SPILL_BASE), .FILL_BASE(FILL_BASE),
    .CLEAN_CODE(CLEAN_CODE), .OTHER_FLAG(OTHER_FLAG)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cmdSave(cmdSave), .cmdRestore(cmdRestore), .cmdFlush(cmdFlush),
    .cmdSaved(cmdSaved), .cmdRestored(cmdRestored), .anyWr(anyWr),
    .cansave(cansave), .canrestore(canrestore), .otherwin(otherwin),
    .cleanwin(cleanwin), .wstate(wstate),
    .stb(stb), .trapValid(trapValid), .trapType(trapType)
  );

  win_acct_dp #(.NWIN(NWIN), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .wrCansave(wrCansave), .wrCanrestore(wrCanrestore), .wrOtherwin(wrOtherwin),
    .wrCleanwin(wrCleanwin), .wrCwp(wrCwp), .wrCntData(wrCntData),
    .wrWstate(wrWstate), .wrWstateData(wrWstateData),
    .cansave(cansave), .canrestore(canrestore), .otherwin(otherwin),
    .cleanwin(cleanwin), .cwp(cwp), .wstate(wstate)
  );

  AST_TRAP_FREEZES: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |-> ($stable(cansave) && $stable(canrestore) && $stable(otherwin)
                   && $stable(cleanwin) && $stable(cwp))); // R10

  AST_CLEAN_CEILING: assert property (@(posedge clk) disable iff (!rstN)
    (cmdRestored && !cmdSave && !cmdRestore && !cmdFlush && !cmdSaved && !anyWr
     && cleanwin == CLEAN_MAX) |=> (cleanwin == CLEAN_MAX)); // R9
endmodule

// File: tb/win_acct_unit_bench.sv
`timescale 1ns/1ps
module win_acct_unit_bench;
  localparam int NWIN = 8;
  localparam int CW = 3;
  localparam int SPILL = 'h080;
  localparam int FILL = 'h0C0;
  localparam int CLEAN = 'h024;
  localparam int OTHER = 'h020;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdSave = 0, cmdRestore = 0, cmdFlush = 0, cmdSaved = 0, cmdRestored = 0;
  logic wrCansave = 0, wrCanrestore = 0, wrOtherwin = 0, wrCleanwin = 0, wrCwp = 0, wrWstate = 0;
  logic [CW-1:0] wrCntData = '0;
  logic [5:0] wrWstateData = '0;
  logic [CW-1:0] cansave, canrestore, otherwin, cleanwin, cwp;
  logic [5:0] wstate;
  logic trapValid;
  logic [8:0] trapType;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  win_acct_unit u_win_acct_unit (
    .clk(clk), .rstN(rstN),
    .cmdSave(cmdSave), .cmdRestore(cmdRestore), .cmdFlush(cmdFlush),
    .cmdSaved(cmdSaved), .cmdRestored(cmdRestored),
    .wrCansave(wrCansave), .wrCanrestore(wrCanrestore), .wrOtherwin(wrOtherwin),
    .wrCleanwin(wrCleanwin), .wrCwp(wrCwp), .wrCntData(wrCntData),
    .wrWstate(wrWstate), .wrWstateData(wrWstateData),
    .cansave(cansave), .canrestore(canrestore), .otherwin(otherwin),
    .cleanwin(cleanwin), .cwp(cwp), .wstate(wstate),
    .trapValid(trapValid), .trapType(trapType)
  );

  function automatic int expCode(int base, int ow, int ws);
    if (ow != 0) return base | OTHER | (((ws >> 3) & 7) << 2);
    return base | ((ws & 7) << 2);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    cmdSave = 0; cmdRestore = 0; cmdFlush = 0; cmdSaved = 0; cmdRestored = 0;
    wrCansave = 0; wrCanrestore = 0; wrOtherwin = 0; wrCleanwin = 0; wrCwp = 0; wrWstate = 0;
  endtask

  task automatic setAll(int cs, int cr, int ow, int cl, int cp, int ws);
    wrCansave = 1; wrCntData = CW'(cs); step();
    wrCanrestore = 1; wrCntData = CW'(cr); step();
    wrOtherwin = 1; wrCntData = CW'(ow); step();
    wrCleanwin = 1; wrCntData = CW'(cl); step();
    wrCwp = 1; wrCntData = CW'(cp); step();
    wrWstate = 1; wrWstateData = 6'(ws); step();
  endtask

  task automatic chkState(string req, int cs, int cr, int ow, int cl, int cp);
    chk({req, " cansave"}, cansave, cs);
    chk({req, " canrestore"}, canrestore, cr);
    chk({req, " otherwin"}, otherwin, ow);
    chk({req, " cleanwin"}, cleanwin, cl);
    chk({req, " cwp"}, cwp, cp);
  endtask

  task automatic testReset();
    chkState("R1 reset", NWIN - 2, 0, 0, NWIN - 1, 0);
    chk("R1 wstate", wstate, 0);
    chk("R1 trapValid", trapValid, 0);
  endtask

  task automatic testSaveRestore();
    cmdSave = 1; step();
    chk("R4 no trap", trapValid, 0);
    chkState("R4 save wraps cwp", 5, 1, 0, 7, 7);
    cmdRestore = 1; step();
    chk("R5 no trap", trapValid, 0);
    chkState("R5 restore wraps cwp", 6, 0, 0, 7, 0);
    setAll(6, 0, 0, 7, 3, 6'b101_011);
    cmdRestore = 1; step();
    chk("R5 fill trap", trapValid, 1);
    chk("R6 fill code ow=0", trapType, expCode(FILL, 0, 6'b101_011));
    chkState("R10 fill unchanged", 6, 0, 0, 7, 3);
    step();
    chk("R11 pulse ends", trapValid, 0);
  endtask

  task automatic testSpill();
    setAll(0, 4, 0, 7, 2, 6'b101_011);
    cmdSave = 1; step();
    chk("R2 spill trap", trapValid, 1);
    chk("R6 spill code ow=0", trapType, expCode(SPILL, 0, 6'b101_011));
    chkState("R10 spill unchanged", 0, 4, 0, 7, 2);
    setAll(0, 4, 2, 7, 2, 6'b101_011);
    cmdSave = 1; step();
    chk("R2 spill trap other", trapValid, 1);
    chk("R6 spill code ow!=0", trapType, expCode(SPILL, 2, 6'b101_011));
    chkState("R10 spill other unchanged", 0, 4, 2, 7, 2);
  endtask

  task automatic testClean();
    setAll(3, 2, 0, 2, 4, 0);
    cmdSave = 1; step();
    chk("R3 clean trap", trapValid, 1);
    chk("R3 clean code", trapType, CLEAN);
    chkState("R10 clean unchanged", 3, 2, 0, 2, 4);
    setAll(3, 2, 0, 3, 4, 0);
    cmdSave = 1; step();
    chk("R3 clean avail no trap", trapValid, 0);
    chkState("R4 save mid", 2, 3, 0, 3, 3);
  endtask

  task automatic testFlush();
    setAll(6, 0, 0, 7, 1, 6'b000_110);
    cmdFlush = 1; step();
    chk("R7 flush ok quiet", trapValid, 0);
    chkState("R7 flush ok unchanged", 6, 0, 0, 7, 1);
    setAll(3, 0, 0, 7, 1, 6'b000_110);
    cmdFlush = 1; step();
    chk("R7 flush trap", trapValid, 1);
    chk("R7 flush code", trapType, expCode(SPILL, 0, 6'b000_110));
    chkState("R7 flush trap unchanged", 3, 0, 0, 7, 1);
  endtask

  task automatic testSaved();
    setAll(2, 3, 2, 5, 1, 0);
    cmdSaved = 1; step();
    chkState("R8 saved other", 3, 3, 1, 5, 1);
    setAll(2, 3, 0, 5, 1, 0);
    cmdSaved = 1; step();
    chkState("R8 saved normal", 3, 2, 0, 5, 1);
  endtask

  task automatic testRestored();
    setAll(4, 1, 0, 7, 5, 0);
    cmdRestored = 1; step();
    chkState("R9 restored at ceiling", 3, 2, 0, 7, 5);
    setAll(4, 1, 2, 3, 5, 0);
    cmdRestored = 1; step();
    chkState("R9 restored other", 4, 2, 1, 4, 5);
  endtask

  task automatic testPriority();
    setAll(5, 1, 0, 7, 4, 0);
    cmdSave = 1; cmdRestore = 1; step();
    chkState("R12 save over restore", 4, 2, 0, 7, 3);
    cmdRestore = 1; cmdSaved = 1; step();
    chkState("R12 restore over saved", 5, 1, 0, 7, 4);
    cmdSave = 1; wrCleanwin = 1; wrCntData = 3'd2; step();
    chk("R12 write blocks command trap", trapValid, 0);
    chkState("R12 write blocks command", 5, 1, 0, 2, 4);
    setAll(0, 1, 0, 7, 4, 0);
    cmdSave = 1; wrWstate = 1; wrWstateData = 6'b000_001; step();
    chk("R12 write blocks trap", trapValid, 0);
    chk("R12 wstate written", wstate, 1);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    step(); step();
    rstN = 1;
    testReset();
    testSaveRestore();
    testSpill();
    testClean();
    testFlush();
    testSaved();
    testRestored();
    testPriority();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule